// File: doc/BRIEF.md
# Stepwise Sequenced Integer Divider

This block carries out an unsigned integer division as a series of separate operations issued by a microcode sequencer. A begin operation loads the divisor and divides the upper word of a double-width dividend, leaving a partial quotient and remainder in internal registers. Each step operation then takes the lower word of the dividend and a count of its bits that have not yet been consumed. It moves the highest unconsumed bit into the remainder, extends the quotient by one bit and returns the reduced count. The sequencer feeds that count back into the next step. Two read operations copy the quotient or the remainder to the result port.

Operations are accepted on a valid/ready pair. The control is a four-state machine:
- IDLE: ready is high.
- HIGH_DIV: the begin operation runs here for one cycle per bit of the upper word, then returns to IDLE.
- LOW_STEP: a step operation spends one cycle here, then returns to IDLE.
- UNLOAD: a read operation spends one cycle here, then returns to IDLE.

Transitions leave IDLE on an accepted operation, selected by its kind. HIGH_DIV returns when its bit counter reaches its last value, and LOW_STEP and UNLOAD always return on the next edge. The second operand of any operation may be taken from an immediate input in place of the register operand. A step may also update a sticky "bits exhausted" flag. Signed fix-up and divide-by-zero trapping are not part of the block.

Top module: `stepdiv_unit`

## Requirements
- R1: After reset, op_ready is 1, res_valid is 0, bits_gone_flag is 0, and reading the quotient or the remainder returns 0.
- R2: A begin operation (op_kind 0) with upper word H and divisor D holds op_ready low for exactly W cycles after acceptance. It then leaves quotient H/D and remainder H mod D. It produces no res_valid pulse.
- R3: With op_use_imm at 1, op_imm replaces op_src_b as the second operand, both as the divisor of a begin and as the count of a step.
- R4: A step operation (op_kind 1) with count n (1..W) takes bit n-1 of op_src_a and forms S = 2·remainder + bit. The new quotient is the old quotient shifted left one place, with a 1 inserted when S ≥ divisor. The new remainder is S − divisor when S ≥ divisor, and S otherwise. The result is n−1.
- R5: A begin followed by W steps with counts W, W−1, …, 1 leaves the low W bits of the double-width quotient {H,L}/D and the remainder {H,L} mod D.
- R6: A step with count 0 returns result 0 and leaves quotient and remainder unchanged.
- R7: A step count larger than W is treated as W.
- R8: A step with op_flag_en at 1 sets bits_gone_flag to 1 when its result count is 0, and to 0 otherwise. Steps without op_flag_en, begin operations and reads never change the flag.
- R9: op_kind 2 returns the quotient and op_kind 3 returns the low W bits of the remainder on res_data. Reads change no internal state.
- R10: For a step or read accepted at edge k, op_ready is low for one cycle and res_valid is high for exactly one cycle, after edge k+1.
- R11: op_valid presented while op_ready is low is ignored: no result is produced and the division state is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Block can accept an operation |
| op_kind | input | 2 | 0 begin, 1 step, 2 read quotient, 3 read remainder |
| op_use_imm | input | 1 | Take second operand from op_imm |
| op_flag_en | input | 1 | Step may update bits_gone_flag |
| op_src_a | input | W | Upper dividend word (begin) or lower dividend word (step) |
| op_src_b | input | W | Divisor (begin) or unconsumed bit count (step) |
| op_imm | input | W | Immediate second operand |
| res_valid | output | 1 | res_data holds a result this cycle |
| res_data | output | W | Remaining count (step) or quotient/remainder (read) |
| bits_gone_flag | output | 1 | Last flag-enabled step left no unconsumed bits |

## Verification
The hardest case to reach is a full sequence in which the quotient bits from the begin stage overflow out of the register and the remainder reaches the divisor boundary on many steps. The bench builds this case by chaining the returned count back into the next step for a whole word, with an upper word at or above the divisor and all-ones dividends. It also drives operations against a busy HIGH_DIV to show they are dropped. A double-width reference model in the bench predicts the quotient and remainder after every sequence.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

    typedef enum logic [1:0] {
        OP_BEGIN   = 2'd0,
        OP_STEP    = 2'd1,
        OP_GET_QUO = 2'd2,
        OP_GET_REM = 2'd3
    } sd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH_DIV,
        ST_LOW_STEP,
        ST_UNLOAD
    } sd_state_e;

endpackage

// File: rtl/sd_restore_step.sv
// One restoring-division bit: shift a bit into the remainder, trial subtract.
module sd_restore_step #(
    parameter int W = 32
) (
    input  logic [W:0]   rem_in,
    input  logic         bit_in,
    input  logic [W-1:0] div_in,
    output logic [W:0]   rem_out,
    output logic         q_bit
);
    logic [W:0] shifted;
    logic [W:0] divisor_ext;
    logic [W:0] diff;

    always_comb begin
        shifted     = {rem_in[W-1:0], bit_in};
        divisor_ext = {1'b0, div_in};
        diff        = shifted - divisor_ext;
        q_bit       = (shifted >= divisor_ext);
        rem_out     = q_bit ? diff : shifted;
    end
endmodule

// File: rtl/sd_bit_pick.sv
// Selects the highest unconsumed low-dividend bit and the count left after it.
module sd_bit_pick #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  lo_word,
    input  logic [CW-1:0] cnt_in,
    output logic          bit_out,
    output logic          has_bits,
    output logic [CW-1:0] cnt_left
);
    logic [CW-1:0] idx;

    always_comb begin
        has_bits = (cnt_in != '0);
        idx      = cnt_in - CW'(1);
        cnt_left = has_bits ? idx : '0;
        bit_out  = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (has_bits && (CW'(i) == idx)) bit_out = lo_word[i];
        end
    end
endmodule

// File: rtl/sd_ctrl.sv
// Operation sequencer: IDLE, HIGH_DIV (W cycles), LOW_STEP, UNLOAD.
module sd_ctrl
    import stepdiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      op_valid,
    input  logic [1:0] op_kind,
    output sd_state_e state,
    output logic      op_ready,
    output logic      op_accept
);
    sd_state_e     state_nx;
    logic [CW-1:0] iter_q;
    logic          iter_last;

    assign iter_last = (iter_q == CW'(W - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            iter_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_HIGH_DIV) iter_q <= iter_q + CW'(1);
            else                      iter_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (op_accept) begin
                    unique case (sd_op_e'(op_kind))
                        OP_BEGIN:   state_nx = ST_HIGH_DIV;
                        OP_STEP:    state_nx = ST_LOW_STEP;
                        OP_GET_QUO,
                        OP_GET_REM: state_nx = ST_UNLOAD;
                    endcase
                end
            end
            ST_HIGH_DIV: if (iter_last) state_nx = ST_IDLE;
            ST_LOW_STEP: state_nx = ST_IDLE;
            ST_UNLOAD:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        op_ready  = (state == ST_IDLE);
        op_accept = op_valid && op_ready;
    end
endmodule

// File: rtl/stepdiv_unit.sv
module stepdiv_unit
    import stepdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    output logic         op_ready,
    input  logic [1:0]   op_kind,
    input  logic         op_use_imm,
    input  logic         op_flag_en,
    input  logic [W-1:0] op_src_a,
    input  logic [W-1:0] op_src_b,
    input  logic [W-1:0] op_imm,
    output logic         res_valid,
    output logic [W-1:0] res_data,
    output logic         bits_gone_flag
);
    localparam int CW = $clog2(W + 1);

    sd_state_e     state;
    logic          op_accept;

    logic [W-1:0]  div_q;
    logic [W-1:0]  quo_q;
    logic [W:0]    rem_q;
    logic [W-1:0]  hi_sh;
    logic [W-1:0]  lo_q;
    logic [CW-1:0] cnt_q;
    logic          fl_en_q;
    logic          sel_rem_q;

    logic [W-1:0]  opnd_b;
    logic [CW-1:0] cnt_sat;
    logic          pick_bit;
    logic          pick_has;
    logic [CW-1:0] pick_left;
    logic          step_bit;
    logic [W:0]    step_rem;
    logic          step_q;
    logic          upd;

    sd_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .state     (state),
        .op_ready  (op_ready),
        .op_accept (op_accept)
    );

    sd_bit_pick #(.W(W), .CW(CW)) u_pick (
        .lo_word  (lo_q),
        .cnt_in   (cnt_q),
        .bit_out  (pick_bit),
        .has_bits (pick_has),
        .cnt_left (pick_left)
    );

    sd_restore_step #(.W(W)) u_step (
        .rem_in  (rem_q),
        .bit_in  (step_bit),
        .div_in  (div_q),
        .rem_out (step_rem),
        .q_bit   (step_q)
    );

    always_comb begin
        opnd_b   = op_use_imm ? op_imm : op_src_b;
        cnt_sat  = (opnd_b > W'(W)) ? CW'(W) : opnd_b[CW-1:0];
        step_bit = (state == ST_HIGH_DIV) ? hi_sh[W-1] : pick_bit;
        upd      = (state == ST_HIGH_DIV) || ((state == ST_LOW_STEP) && pick_has);
    end

    // division registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            quo_q     <= '0;
            rem_q     <= '0;
            hi_sh     <= '0;
            lo_q      <= '0;
            cnt_q     <= '0;
            fl_en_q   <= 1'b0;
            sel_rem_q <= 1'b0;
        end else begin
            if (op_accept) begin
                fl_en_q <= op_flag_en;
                unique case (sd_op_e'(op_kind))
                    OP_BEGIN: begin
                        div_q <= opnd_b;
                        hi_sh <= op_src_a;
                        quo_q <= '0;
                        rem_q <= '0;
                    end
                    OP_STEP: begin
                        lo_q  <= op_src_a;
                        cnt_q <= cnt_sat;
                    end
                    OP_GET_QUO: sel_rem_q <= 1'b0;
                    OP_GET_REM: sel_rem_q <= 1'b1;
                endcase
            end
            if (state == ST_HIGH_DIV) hi_sh <= {hi_sh[W-2:0], 1'b0};
            if (upd) begin
                rem_q <= step_rem;
                quo_q <= {quo_q[W-2:0], step_q};
            end
        end
    end

    // result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_data       <= '0;
            bits_gone_flag <= 1'b0;
        end else begin
            res_valid <= (state == ST_LOW_STEP) || (state == ST_UNLOAD);
            if (state == ST_LOW_STEP) begin
                res_data <= {{(W - CW){1'b0}}, pick_left};
                if (fl_en_q) bits_gone_flag <= (pick_left == '0);
            end else if (state == ST_UNLOAD) begin
                res_data <= sel_rem_q ? rem_q[W-1:0] : quo_q;
            end
        end
    end
endmodule

// File: rtl/stepdiv_chk.sv
module stepdiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic         op_ready,
    input logic [1:0]   op_kind,
    input logic         res_valid,
    input logic         bits_gone_flag,
    input logic [W:0]   rem_q,
    input logic [W-1:0] div_q
);
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready);

    p_result_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind != 2'd0) |=> ##1 res_valid);

    p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_begin_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind == 2'd0) |=> ##1 !res_valid);

    p_flag_with_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bits_gone_flag) |-> res_valid);

    p_rem_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && div_q != '0) |-> (rem_q < {1'b0, div_q}));
endmodule

bind stepdiv_unit stepdiv_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_ready       (op_ready),
    .op_kind        (op_kind),
    .res_valid      (res_valid),
    .bits_gone_flag (bits_gone_flag),
    .rem_q          (rem_q),
    .div_q          (div_q)
);

// File: tb/tb_stepdiv_unit.sv
`timescale 1ns/1ps
module tb_stepdiv_unit;
    localparam int W = 32;
    localparam longint unsigned MASK = 64'h0000_0000_FFFF_FFFF;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic         op_ready;
    logic [1:0]   op_kind;
    logic         op_use_imm;
    logic         op_flag_en;
    logic [W-1:0] op_src_a;
    logic [W-1:0] op_src_b;
    logic [W-1:0] op_imm;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         bits_gone_flag;

    int n_run  = 0;
    int n_fail = 0;
    longint unsigned mq, mr, mdiv;

    always #2.5 clk = ~clk;

    stepdiv_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_use_imm(op_use_imm), .op_flag_en(op_flag_en),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_imm(op_imm),
        .res_valid(res_valid), .res_data(res_data), .bits_gone_flag(bits_gone_flag)
    );

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] kind, input logic imm, input logic fl,
                        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] im);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1; op_kind = kind; op_use_imm = imm; op_flag_en = fl;
        op_src_a = a; op_src_b = b; op_imm = im;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_step(input logic imm, input logic fl, input logic [W-1:0] lo,
                           input logic [W-1:0] cnt, output logic v, output logic [W-1:0] d);
        send(2'd1, imm, fl, lo, imm ? 32'hDEAD_BEEF : cnt, imm ? cnt : 32'h0BAD_0000);
        @(negedge clk);
        v = res_valid; d = res_data;
    endtask

    task automatic read_val(input logic want_rem, output logic [W-1:0] d);
        send(want_rem ? 2'd3 : 2'd2, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk);
        d = res_data;
    endtask

    task automatic begin_div(input logic imm, input logic [W-1:0] hi,
                             input logic [W-1:0] b, input logic [W-1:0] im, output int busy);
        send(2'd0, imm, 1'b0, hi, b, im);
        busy = 0;
        while (!op_ready) begin
            busy++;
            if (res_valid) check("R2", "res_valid during begin", 1, 0);
            @(negedge clk);
        end
        mdiv = imm ? im : b;
        mq = hi / mdiv; mr = hi % mdiv;
    endtask

    function automatic longint unsigned model_step(input longint unsigned lo, input longint unsigned cnt);
        longint unsigned c, s, b;
        c = (cnt > W) ? W : cnt;
        if (c == 0) return 0;
        b = (lo >> (c - 1)) & 1;
        s = (mr << 1) | b;
        if (s >= mdiv) begin mq = ((mq << 1) | 1) & MASK; mr = s - mdiv; end
        else           begin mq = (mq << 1) & MASK;       mr = s; end
        return c - 1;
    endfunction

    task automatic check_qr(input string req);
        logic [W-1:0] d;
        read_val(1'b0, d); check(req, "quotient", d, mq);
        read_val(1'b1, d); check(req, "remainder", d, mr);
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        check("R1", "op_ready", op_ready, 1);
        check("R1", "res_valid", res_valid, 0);
        check("R1", "flag", bits_gone_flag, 0);
        read_val(1'b0, d); check("R1", "quotient", d, 0);
        read_val(1'b1, d); check("R1", "remainder", d, 0);
    endtask

    task automatic t_begin_reg;
        int busy;
        begin_div(1'b0, 32'd1000, 32'd7, 32'd99, busy);
        check("R2", "busy cycles", busy, W);
        check("R2", "model quotient", mq, 142);
        check_qr("R2");
    endtask

    task automatic t_begin_imm;
        int busy;
        begin_div(1'b1, 32'd200, 32'd5, 32'd13, busy);
        check("R3", "imm quotient model", mq, 15);
        check_qr("R3");
    endtask

    task automatic t_one_step;
        int busy; logic v; logic [W-1:0] d;
        begin_div(1'b0, 32'd6, 32'd7, 32'd0, busy);
        do_step(1'b0, 1'b0, 32'h8000_0000, 32'd32, v, d);
        check("R4", "count after first", d, 31);
        void'(model_step(64'h8000_0000, 32));
        check("R4", "quotient 1", mq, 1);
        check_qr("R4");
        do_step(1'b0, 1'b0, 32'h8000_0000, 32'd31, v, d);
        void'(model_step(64'h8000_0000, 31));
        check("R4", "count after second", d, 30);
        check_qr("R4");
    endtask

    task automatic t_full(input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] dv, input logic imm_cnt);
        int busy; logic v; logic [W-1:0] d; logic [W-1:0] cnt;
        longint unsigned full;
        begin_div(1'b0, hi, dv, '0, busy);
        cnt = W;
        for (int i = 0; i < W; i++) begin
            do_step(imm_cnt, 1'b0, lo, cnt, v, d);
            if (v !== 1'b1) check("R5", "step valid", v, 1);
            cnt = d;
        end
        check("R5", "final count", cnt, 0);
        full = {hi, lo};
        mq = (full / dv) & MASK;
        mr = full % dv;
        check_qr(imm_cnt ? "R3" : "R5");
    endtask

    task automatic t_zero_count;
        int busy; logic v; logic [W-1:0] d;
        begin_div(1'b0, 32'd50, 32'd9, '0, busy);
        do_step(1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, v, d);
        check("R6", "valid", v, 1);
        check("R6", "count", d, 0);
        check_qr("R6");
    endtask

    task automatic t_saturate;
        int busy; logic v; logic [W-1:0] d;
        begin_div(1'b0, 32'd0, 32'd5, '0, busy);
        do_step(1'b0, 1'b0, 32'h8000_0001, 32'd100, v, d);
        void'(model_step(64'h8000_0001, 100));
        check("R7", "count 100", d, 31);
        check_qr("R7");
        do_step(1'b1, 1'b0, 32'h8000_0001, 32'd33, v, d);
        void'(model_step(64'h8000_0001, 33));
        check("R7", "count 33", d, 31);
        check_qr("R7");
    endtask

    task automatic t_flag;
        int busy; logic v; logic [W-1:0] d;
        begin_div(1'b0, 32'd5, 32'd3, '0, busy);
        do_step(1'b0, 1'b1, 32'h1, 32'd1, v, d);
        check("R8", "flag set at zero", bits_gone_flag, 1);
        do_step(1'b0, 1'b1, 32'h1, 32'd5, v, d);
        check("R8", "flag cleared", bits_gone_flag, 0);
        do_step(1'b0, 1'b0, 32'h1, 32'd1, v, d);
        check("R8", "flag held w/o enable", bits_gone_flag, 0);
        do_step(1'b0, 1'b1, 32'h1, 32'd1, v, d);
        begin_div(1'b0, 32'd9, 32'd4, '0, busy);
        check("R8", "flag held over begin", bits_gone_flag, 1);
        read_val(1'b0, d);
        check("R8", "flag held over read", bits_gone_flag, 1);
        do_step(1'b0, 1'b1, 32'h0, 32'd0, v, d);
        check("R8", "flag on zero-count step", bits_gone_flag, 1);
    endtask

    task automatic t_unload;
        int busy; logic [W-1:0] d1, d2;
        begin_div(1'b0, 32'd77, 32'd10, '0, busy);
        read_val(1'b0, d1); read_val(1'b0, d2);
        check("R9", "quotient read", d1, 7);
        check("R9", "quotient reread", d2, 7);
        read_val(1'b1, d1); read_val(1'b0, d2);
        check("R9", "remainder read", d1, 7);
        check("R9", "quotient after rem read", d2, 7);
    endtask

    task automatic t_timing;
        send(2'd1, 1'b0, 1'b0, 32'h0, 32'd3, '0);
        check("R10", "ready low after accept", op_ready, 0);
        check("R10", "no early result", res_valid, 0);
        @(negedge clk);
        check("R10", "result valid", res_valid, 1);
        check("R10", "ready back", op_ready, 1);
        @(negedge clk);
        check("R10", "single pulse", res_valid, 0);
    endtask

    task automatic t_busy_ignore;
        int seen;
        send(2'd0, 1'b0, 1'b0, 32'd100, 32'd9, '0);
        mdiv = 9; mq = 11; mr = 1;
        seen = 0;
        op_valid = 1'b1; op_kind = 2'd1; op_src_a = 32'hFFFF_FFFF; op_src_b = 32'd4;
        for (int i = 0; i < W - 4; i++) begin
            if (i == 10) op_kind = 2'd2;
            if (res_valid) seen++;
            @(negedge clk);
        end
        op_valid = 1'b0;
        while (!op_ready) begin
            if (res_valid) seen++;
            @(negedge clk);
        end
        @(negedge clk);
        if (res_valid) seen++;
        check("R11", "results while busy", seen, 0);
        check_qr("R11");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_kind = '0; op_use_imm = 1'b0;
        op_flag_en = 1'b0; op_src_a = '0; op_src_b = '0; op_imm = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_begin_reg();
        t_begin_imm();
        t_one_step();
        t_full(32'h0001_2345, 32'h6789_ABCD, 32'h000F_0001, 1'b0);
        t_full(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, 1'b0);
        t_full(32'h0000_0ABC, 32'hFFFF_FFFF, 32'h0000_0ABD, 1'b1);
        t_zero_count();
        t_saturate();
        t_flag();
        t_unload();
        t_timing();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule